// File: doc/BRIEF.md
# Logic Probe Indicator Controller

This block is the digital core of a handheld logic probe. It receives converted samples of the tip voltage and sorts each one into high, low or undefined against a threshold pair chosen by a TTL/CMOS mode input. The high and low indicator LEDs follow the most recent sample. A synchronised copy of the raw tip logic input is watched for level changes. Each change lights a pulse LED for a retriggerable window that is measured in housekeeping ticks.

An internal tick (nominally 8 ms) closes a counting window of high and low samples. At each tick the control logic decides whether the sounder plays and which tone it plays: a high tone, a low tone or a pulse tone. When a valid level and a pulse activity window are present together, the choice alternates tick by tick, so the sound warbles. In CMOS mode the precharge output enable is asserted to bias an open tip to mid-rail. In TTL mode it is released.

Top module: `logic_probe_ctrl`

## Requirements
- R1: A sample with `sampleValid` high sets `ledHigh`/`ledLow` on the next clock edge. In TTL mode (`modeTtl`=1) a code below 164 is low and a code of 410 or more is high. In CMOS mode a code below 307 is low and a code of 717 or more is high. Codes between the two thresholds light neither LED, and the two LEDs are never lit together.
- R2: Between valid samples, `ledHigh` and `ledLow` hold their values whatever `sampleCode` does.
- R3: Each valid sample updates `prechargeOe` to 1 in CMOS mode and to 0 in TTL mode. A change of mode without a sample does not change it.
- R4: A rising or a falling edge on `tipRaw`, after a two-flop synchronizer, lights `ledPulse` and loads a timer with PULSE_TICKS ticks. The LED goes dark after PULSE_TICKS ticks pass with no further edge, and each new edge restarts the window.
- R5: A tick occurs every TICK_CYCLES clocks. The high and low sample counts cover only the samples since the previous tick, and are cleared when the tick consumes them.
- R6: When a window holds no high or low sample and no pulse window is active, `sounder` stays at 0.
- R7: If a window has at least as many high samples as low ones (and at least one), the high tone plays, toggling every HALF_HIGH clocks. If low samples are the majority, the low tone plays, toggling every HALF_LOW clocks.
- R8: With an active pulse window and no valid level, the pulse tone plays, toggling every HALF_PULSE clocks.
- R9: When the level tone chosen at a tick equals the tone of the previous tick and a pulse window is active, the pulse tone is used instead. The result alternates between the level tone and the pulse tone.
- R10: The sample counters saturate at 2^CNT_W-1 instead of wrapping.
- R11: After reset all LEDs are off, `sounder` is 0 and `prechargeOe` is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Marks a new converted tip sample |
| sampleCode | input | ADC_W | Converted tip voltage code |
| modeTtl | input | 1 | 1 selects TTL thresholds, 0 selects CMOS |
| tipRaw | input | 1 | Unsynchronised tip logic level |
| ledHigh | output | 1 | Last sample was a valid high |
| ledLow | output | 1 | Last sample was a valid low |
| ledPulse | output | 1 | Pulse activity window is open |
| prechargeOe | output | 1 | Output enable of the mid-rail precharge drive |
| sounder | output | 1 | Square-wave tone to the transducer |

## Verification
The warble is the hardest behaviour to reach from the ports. It needs a valid level to be counted in every tick window while the pulse timer never runs out, and the bench has no view of the tick phase. The stimulus therefore runs a steady stream of high samples on a stride that divides the window, and toggles the tip more often than the pulse window lasts. The bench then measures many sounder half-periods over several windows and requires both the high-tone and the pulse-tone lengths to appear. Saturation is reached the same way: exactly one more low sample per window than the counter can hold, so a wrapping counter would fall silent.

// File: rtl/probe_pkg.sv
package probe_pkg;
  typedef enum logic [1:0] {
    TONE_NONE  = 2'd0,
    TONE_HIGH  = 2'd1,
    TONE_LOW   = 2'd2,
    TONE_PULSE = 2'd3
  } tone_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  clearCounts;
    tone_e toneSel;
  } probe_ctrl_s;
endpackage

// File: rtl/probe_datapath.sv
module probe_datapath
  import probe_pkg::*;
#(
  parameter int ADC_W      = 10,
  parameter int CNT_W      = 8,
  parameter int TTL_LO     = 164,
  parameter int TTL_HI     = 410,
  parameter int CMOS_LO    = 307,
  parameter int CMOS_HI    = 717,
  parameter int HALF_HIGH  = 2000,
  parameter int HALF_LOW   = 8000,
  parameter int HALF_PULSE = 4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [ADC_W-1:0] sampleCode,
  input  logic             modeTtl,
  input  logic             tipRaw,
  input  probe_ctrl_s      ctrl,
  output logic [CNT_W-1:0] highCnt,
  output logic [CNT_W-1:0] lowCnt,
  output logic             tipEdge,
  output logic             ledHigh,
  output logic             ledLow,
  output logic             prechargeOe,
  output logic             sounder
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int HALF_MAX = (HALF_HIGH > HALF_LOW)
                            ? ((HALF_HIGH > HALF_PULSE) ? HALF_HIGH : HALF_PULSE)
                            : ((HALF_LOW > HALF_PULSE) ? HALF_LOW : HALF_PULSE);
  localparam int DIV_W = $clog2(HALF_MAX + 1);

  // ---------------- classification ----------------
  logic [ADC_W-1:0] loTh, hiTh;
  logic isHigh, isLow;

  always_comb begin
    loTh   = modeTtl ? ADC_W'(TTL_LO) : ADC_W'(CMOS_LO);
    hiTh   = modeTtl ? ADC_W'(TTL_HI) : ADC_W'(CMOS_HI);
    isHigh = sampleCode >= hiTh;
    isLow  = sampleCode < loTh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledHigh     <= 1'b0;
      ledLow      <= 1'b0;
      prechargeOe <= 1'b0;
    end else if (sampleValid) begin
      ledHigh     <= isHigh;
      ledLow      <= isLow;
      prechargeOe <= !modeTtl;
    end
  end

  p_led_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(ledHigh && ledLow));

  p_led_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(ledHigh) && $stable(ledLow)));

  p_precharge_r3: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (prechargeOe == !$past(modeTtl)));

  // ---------------- window counters ----------------
  logic [1:0] hitVec;
  assign hitVec = {sampleValid && isHigh, sampleValid && isLow};

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cnt <= '0;
      else if (ctrl.clearCounts)
        cnt <= hitVec[g] ? CNT_W'(1) : '0;
      else if (hitVec[g] && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end
  assign highCnt = g_cnt[1].cnt;
  assign lowCnt  = g_cnt[0].cnt;

  p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (highCnt == CNT_MAX && !ctrl.clearCounts) |=> highCnt == CNT_MAX);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.clearCounts && !sampleValid) |=> (highCnt == '0 && lowCnt == '0));

  // ---------------- tip synchronizer / edge ----------------
  logic [2:0] tipSync;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tipSync <= '0;
    else       tipSync <= {tipSync[1:0], tipRaw};
  end
  assign tipEdge = tipSync[2] ^ tipSync[1];

  // ---------------- tone generator ----------------
  tone_e            prevSel;
  logic [DIV_W-1:0] divCnt, halfLen;

  always_comb begin
    unique case (ctrl.toneSel)
      TONE_HIGH:  halfLen = DIV_W'(HALF_HIGH);
      TONE_LOW:   halfLen = DIV_W'(HALF_LOW);
      TONE_PULSE: halfLen = DIV_W'(HALF_PULSE);
      default:    halfLen = DIV_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= TONE_NONE;
      divCnt  <= '0;
      sounder <= 1'b0;
    end else begin
      prevSel <= ctrl.toneSel;
      if (ctrl.toneSel == TONE_NONE) begin
        divCnt  <= '0;
        sounder <= 1'b0;
      end else if (ctrl.toneSel != prevSel) begin
        divCnt <= '0;
      end else if (divCnt == halfLen - 1'b1) begin
        divCnt  <= '0;
        sounder <= !sounder;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  p_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.toneSel == TONE_NONE) |=> !sounder);
endmodule

// File: rtl/probe_control.sv
module probe_control
  import probe_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TICK_CYCLES = 64000,
  parameter int PULSE_TICKS = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] highCnt,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic             tipEdge,
  output probe_ctrl_s      ctrl,
  output logic             ledPulse
);
  localparam int TICK_W  = $clog2(TICK_CYCLES);
  localparam int TIMER_W = $clog2(PULSE_TICKS + 1);

  logic [TICK_W-1:0]  tickCnt;
  logic               tick;
  logic [TIMER_W-1:0] pulseTimer;
  logic               pulseActive;
  tone_e              levelTone, nextSel, lastTone;

  assign tick = tickCnt == TICK_W'(TICK_CYCLES - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  // pulse stretch timer, counted in ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pulseTimer <= '0;
    else if (tipEdge)
      pulseTimer <= TIMER_W'(PULSE_TICKS);
    else if (tick && pulseTimer != '0)
      pulseTimer <= pulseTimer - 1'b1;
  end
  assign pulseActive = pulseTimer != '0;
  assign ledPulse    = pulseActive;

  p_pulse_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    tipEdge |=> pulseTimer == TIMER_W'(PULSE_TICKS));

  p_pulse_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && !tick) |=> ledPulse);

  // tone selection
  always_comb begin
    if (highCnt == '0 && lowCnt == '0) levelTone = TONE_NONE;
    else if (highCnt >= lowCnt)        levelTone = TONE_HIGH;
    else                               levelTone = TONE_LOW;

    if (levelTone == TONE_NONE)
      nextSel = pulseActive ? TONE_PULSE : TONE_NONE;
    else if (pulseActive && levelTone == lastTone)
      nextSel = TONE_PULSE;
    else
      nextSel = levelTone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lastTone <= TONE_NONE;
    else if (tick) lastTone <= nextSel;
  end

  assign ctrl.clearCounts = tick;
  assign ctrl.toneSel     = lastTone;

  p_warble_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pulseActive && levelTone != TONE_NONE && levelTone == lastTone)
      |=> lastTone == TONE_PULSE);

  p_sel_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(lastTone));
endmodule

// File: rtl/logic_probe_ctrl.sv
module logic_probe_ctrl
  import probe_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int CNT_W       = 8,
  parameter int TICK_CYCLES = 64000,
  parameter int PULSE_TICKS = 13,
  parameter int HALF_HIGH   = 2000,
  parameter int HALF_LOW    = 8000,
  parameter int HALF_PULSE  = 4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [ADC_W-1:0] sampleCode,
  input  logic             modeTtl,
  input  logic             tipRaw,
  output logic             ledHigh,
  output logic             ledLow,
  output logic             ledPulse,
  output logic             prechargeOe,
  output logic             sounder
);
  probe_ctrl_s      ctrl;
  logic [CNT_W-1:0] highCnt, lowCnt;
  logic             tipEdge;

  probe_datapath #(
    .ADC_W(ADC_W), .CNT_W(CNT_W),
    .HALF_HIGH(HALF_HIGH), .HALF_LOW(HALF_LOW), .HALF_PULSE(HALF_PULSE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .modeTtl(modeTtl), .tipRaw(tipRaw), .ctrl(ctrl), .highCnt(highCnt),
    .lowCnt(lowCnt), .tipEdge(tipEdge), .ledHigh(ledHigh), .ledLow(ledLow),
    .prechargeOe(prechargeOe), .sounder(sounder)
  );

  probe_control #(
    .CNT_W(CNT_W), .TICK_CYCLES(TICK_CYCLES), .PULSE_TICKS(PULSE_TICKS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .highCnt(highCnt), .lowCnt(lowCnt),
    .tipEdge(tipEdge), .ctrl(ctrl), .ledPulse(ledPulse)
  );
endmodule

// File: tb/logic_probe_ctrl_test.sv
module logic_probe_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 64;
  localparam int PT   = 3;
  localparam int HH = 2, HL = 8, HP = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic sampleValid = 1'b0, modeTtl = 1'b1, tipRaw = 1'b0;
  logic [9:0] sampleCode = '0;
  logic ledHigh, ledLow, ledPulse, prechargeOe, sounder;

  int checks = 0, errors = 0;
  bit done = 0;

  // background stimulus control
  bit manValid = 0; logic [9:0] manCode = '0; bit manTip = 0;
  int patLen = 0, patStride = 1, tipPeriod = 0;
  logic [9:0] pat [4];
  int cyc = 0, idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_probe_ctrl #(
    .ADC_W(10), .CNT_W(4), .TICK_CYCLES(TICK), .PULSE_TICKS(PT),
    .HALF_HIGH(HH), .HALF_LOW(HL), .HALF_PULSE(HP)
  ) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .modeTtl(modeTtl), .tipRaw(tipRaw), .ledHigh(ledHigh), .ledLow(ledLow),
    .ledPulse(ledPulse), .prechargeOe(prechargeOe), .sounder(sounder)
  );

  always @(negedge clk) begin
    cyc++;
    if (patLen == 0) begin
      sampleValid = manValid; sampleCode = manCode;
    end else if (cyc % patStride == 0) begin
      sampleValid = 1'b1; sampleCode = pat[idx]; idx = (idx + 1) % patLen;
    end else begin
      sampleValid = 1'b0;
    end
    if (tipPeriod == 0) tipRaw = manTip;
    else if (cyc % tipPeriod == 0) tipRaw = ~tipRaw;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample(logic ttl, logic [9:0] code);
    @(posedge clk); modeTtl = ttl; manValid = 1; manCode = code;
    @(posedge clk); manValid = 0;
    @(negedge clk);
  endtask

  // cycles between two sounder changes, -1 on timeout
  task automatic measureHalf(output int h);
    logic prev;
    int t;
    h = -1; t = 0;
    @(negedge clk); prev = sounder;
    while (sounder == prev && t < 200) begin @(negedge clk); t++; end
    if (t >= 200) return;
    prev = sounder; t = 0;
    while (sounder == prev && t < 200) begin @(negedge clk); t++; end
    if (t < 200) h = t;
  endtask

  task automatic stopPattern();
    @(posedge clk); patLen = 0; tipPeriod = 0; manTip = tipRaw;
  endtask

  task automatic startPattern(int stride, int len, logic [9:0] a, logic [9:0] b, logic [9:0] c);
    @(posedge clk);
    pat[0] = a; pat[1] = b; pat[2] = c; pat[3] = a;
    idx = 0; patStride = stride; patLen = len;
  endtask

  task automatic expectSilence(string req);
    int seen = 0;
    waitCycles(3*TICK);
    for (int i = 0; i < 2*TICK; i++) begin @(negedge clk); if (sounder) seen = 1; end
    check(req, seen, 0);
  endtask

  task automatic expectTone(string req, int half);
    int h;
    waitCycles(3*TICK);
    for (int i = 0; i < 3; i++) begin measureHalf(h); check(req, h, half); end
  endtask

  task automatic testReset();
    check("R11 ledHigh", ledHigh, 0); check("R11 ledLow", ledLow, 0);
    check("R11 ledPulse", ledPulse, 0); check("R11 sounder", sounder, 0);
    check("R11 prechargeOe", prechargeOe, 0);
  endtask

  task automatic testThresholds();
    sample(1, 163); check("R1 ttl 163 low", {ledHigh, ledLow}, 1);
    sample(1, 164); check("R1 ttl 164 undef", {ledHigh, ledLow}, 0);
    sample(1, 409); check("R1 ttl 409 undef", {ledHigh, ledLow}, 0);
    sample(1, 410); check("R1 ttl 410 high", {ledHigh, ledLow}, 2);
    sample(0, 306); check("R1 cmos 306 low", {ledHigh, ledLow}, 1);
    sample(0, 307); check("R1 cmos 307 undef", {ledHigh, ledLow}, 0);
    sample(0, 410); check("R1 cmos 410 undef", {ledHigh, ledLow}, 0);
    sample(0, 716); check("R1 cmos 716 undef", {ledHigh, ledLow}, 0);
    sample(0, 717); check("R1 cmos 717 high", {ledHigh, ledLow}, 2);
  endtask

  task automatic testHoldAndPrecharge();
    // last sample was CMOS high
    check("R3 cmos drives", prechargeOe, 1);
    @(posedge clk); manCode = 10'd0; modeTtl = 1;
    waitCycles(4);
    check("R2 hold high", {ledHigh, ledLow}, 2);
    check("R3 no sample no change", prechargeOe, 1);
    sample(1, 10'd500);
    check("R3 ttl released", prechargeOe, 0);
  endtask

  task automatic testPulse();
    @(posedge clk); manTip = 1;
    waitCycles(5);
    check("R4 rising edge lights", ledPulse, 1);
    waitCycles(2*TICK - 10);
    check("R4 still on", ledPulse, 1);
    waitCycles(TICK + 16);
    check("R4 expired", ledPulse, 0);
    // falling edge and retrigger
    @(posedge clk); manTip = 0;
    waitCycles(2*TICK - 4);
    check("R4 falling edge on", ledPulse, 1);
    @(posedge clk); manTip = 1;
    waitCycles(2*TICK);
    check("R4 retrigger extends", ledPulse, 1);
    waitCycles(TICK + 16);
    check("R4 retrigger expiry", ledPulse, 0);
  endtask

  task automatic testTones();
    modeTtl = 1;
    expectSilence("R6 idle silent");
    startPattern(1, 1, 10'd300, 10'd300, 10'd300);
    expectSilence("R6 undefined only silent");
    startPattern(4, 1, 10'd900, 10'd900, 10'd900);
    expectTone("R7 high tone", HH);
    startPattern(4, 3, 10'd10, 10'd10, 10'd900);
    expectTone("R7 low majority", HL);
    startPattern(4, 2, 10'd900, 10'd10, 10'd10);
    expectTone("R7 tie gives high", HH);
    stopPattern();
    expectSilence("R5 counts cleared");
    startPattern(4, 1, 10'd10, 10'd10, 10'd10);
    expectTone("R10 saturated low count", HL);
    stopPattern();
  endtask

  task automatic testPulseTone();
    int h, seen2, seen4, seen8;
    @(posedge clk); tipPeriod = 40;
    expectTone("R8 pulse tone", HP);
    startPattern(4, 1, 10'd900, 10'd900, 10'd900);
    waitCycles(2*TICK);
    seen2 = 0; seen4 = 0; seen8 = 0;
    for (int i = 0; i < 40; i++) begin
      measureHalf(h);
      if (h == HH) seen2 = 1;
      if (h == HP) seen4 = 1;
      if (h == HL) seen8 = 1;
    end
    check("R9 warble high part", seen2, 1);
    check("R9 warble pulse part", seen4, 1);
    check("R9 no low tone", seen8, 0);
    stopPattern();
    waitCycles(5*TICK);
    check("R4 pulse off after stop", ledPulse, 0);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    waitCycles(2);
    testThresholds();
    testHoldAndPrecharge();
    testPulse();
    testTones();
    testPulseTone();
    finish();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end
endmodule